// File: doc/BRIEF.md
# Floating-Point Control and Status Register with Exception Gating

This block holds the control and status word that sits next to a floating-point datapath. The datapath reports each finished operation as a single-cycle pulse. The pulse carries the IEEE exceptions the operation raised, an unimplemented-operation indication, a denormal-result indication and, for compares, the compare outcome. The block then does four things:

- It records the last operation's causes.
- It accumulates sticky flags for operations that do not trap.
- It holds the compare condition.
- It raises a level exception request whenever an enabled cause is pending.

It also drives the rounding mode and flush-to-zero controls to the arithmetic units.

Software writes the whole word in one cycle. Software reads use a valid/ready request. The request is accepted only when the read engine is idle (`rd_req_ready` high), and the requester holds `rd_req_valid` until it sees ready. After acceptance, the engine waits for the datapath to report no work in flight, then returns the word as a one-cycle `rd_rsp_valid` pulse. If an operation traps while the read is waiting, the read is returned with `rd_rsp_abort` set so that software can reissue it. The response has no back-pressure: the requester must take the pulse when it appears.

Top module: `fpcsr_ctrl`

## Requirements
- R1: After reset the whole word reads as zero, `rnd_mode` is 00, and `flush_zero`, `cond_out` and `exc_req` are low.
- R2: The word layout is as follows:
  - bit 24: flush-to-zero
  - bit 23: condition
  - bits 17:12: causes, ordered E,V,Z,O,U,I from high to low
  - bits 11:7: enables, ordered V,Z,O,U,I
  - bits 6:2: flags, ordered V,Z,O,U,I
  - bits 1:0: rounding mode

  A software write (`sw_wr_en`) loads every one of these fields, and all other bits always read as zero.
- R3: `rnd_mode` follows bits 1:0 (00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf) and `flush_zero` follows bit 24, from the cycle after the write.
- R4: An operation with `op_kind` 01 (arith) or 10 (compare) overwrites all six cause bits with its report. `op_exc` bits 4..0 are V,Z,O,U,I and `op_unimpl` is E. Several bits may be set at once.
- R5: An operation with `op_kind` 00 or 11 (load, store or move) changes neither causes, flags nor condition, and never asserts `op_commit`.
- R6: `exc_req` is high whenever cause E is set, or any of the causes V..I is set together with its enable.
- R7: A trapping arith/compare operation updates only the causes: flags and condition keep their values, and `op_commit` is low in the report cycle.
- R8: A non-trapping arith/compare operation drives `op_commit` high in its report cycle and ORs its IEEE exceptions into the flags. Operations never clear a flag.
- R9: A non-trapping compare loads the condition bit (and `cond_out`) with `op_cmp_true`.
- R10: A denormal result (`op_denorm`) sets cause E when flush-to-zero is 0 and adds no cause when it is 1.
- R11: A software write that leaves a cause bit and its enable both set raises `exc_req` in the very next cycle.
- R12: A read accepted while `fpu_busy` is high produces no response until `fpu_busy` has been low at a clock edge. The response then appears in the following cycle, with `rd_rsp_abort` low and the current word on `rd_rsp_data`.
- R13: If an operation traps while an accepted read is waiting, the read ends with `rd_rsp_valid` and `rd_rsp_abort` both high and the data at zero.
- R14: A software write in the same cycle as an operation report takes precedence: the operation is dropped, the word takes the written value, and `op_commit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation report pulse |
| op_kind | input | 2 | 00 move, 01 arith, 10 compare, 11 move |
| op_exc | input | 5 | IEEE exceptions raised, V,Z,O,U,I from bit 4 down |
| op_unimpl | input | 1 | Operation needs software emulation |
| op_denorm | input | 1 | Result was denormal before flushing |
| op_cmp_true | input | 1 | Compare outcome |
| op_commit | output | 1 | Result may be stored (combinational) |
| fpu_busy | input | 1 | Operations still in flight |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 32 | Software write value |
| rd_req_valid | input | 1 | Read request valid |
| rd_req_ready | output | 1 | Read engine idle, request accepted |
| rd_rsp_valid | output | 1 | Read response pulse |
| rd_rsp_abort | output | 1 | Read dropped because of a trap |
| rd_rsp_data | output | 32 | Read value |
| rnd_mode | output | 2 | Rounding mode to the arithmetic units |
| flush_zero | output | 1 | Flush denormal results to zero |
| cond_out | output | 1 | Compare condition line |
| exc_req | output | 1 | Floating-point exception request |

## Verification
Different kinds of corrupted state show up at different ports and at different times:

- A corrupted cause or enable field shows on `exc_req` one cycle after the update that produced it.
- A wrongly set or cleared flag stays invisible until a read response. That response arrives two cycles after acceptance when the datapath is idle, and later when it is busy.
- A wrong condition bit appears on `cond_out` after one cycle.
- A stuck read engine shows as a missing or premature `rd_rsp_valid`, or as a wrong abort flag on the next trap.

The bench therefore reads the whole word back after each stimulus, and sweeps every enable mask against every cause report.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;

  localparam int FCSR_W    = 32;
  localparam int IEEE_N    = 5;
  localparam int CAUSE_W   = IEEE_N + 1;
  localparam int RM_W      = 2;
  localparam int RM_LO     = 0;
  localparam int FLAG_LO   = RM_LO + RM_W;
  localparam int EN_LO     = FLAG_LO + IEEE_N;
  localparam int CAUSE_LO  = 12;
  localparam int COND_POS  = 23;
  localparam int FS_POS    = 24;

  typedef enum logic [1:0] {
    OPK_MOVE  = 2'b00,
    OPK_ARITH = 2'b01,
    OPK_CMP   = 2'b10,
    OPK_XMOVE = 2'b11
  } opkind_e;

  typedef enum logic [1:0] {
    RD_IDLE = 2'b00,
    RD_WAIT = 2'b01,
    RD_RESP = 2'b10
  } rdst_e;

  typedef struct packed {
    logic                fs;
    logic                cond;
    logic [CAUSE_W-1:0]  cause;
    logic [IEEE_N-1:0]   en;
    logic [IEEE_N-1:0]   flags;
    logic [RM_W-1:0]     rm;
  } csr_t;

  function automatic logic [FCSR_W-1:0] csr_pack(input csr_t c);
    logic [FCSR_W-1:0] w;
    w = '0;
    w[FS_POS]                   = c.fs;
    w[COND_POS]                 = c.cond;
    w[CAUSE_LO +: CAUSE_W]      = c.cause;
    w[EN_LO +: IEEE_N]          = c.en;
    w[FLAG_LO +: IEEE_N]        = c.flags;
    w[RM_LO +: RM_W]            = c.rm;
    return w;
  endfunction

  function automatic csr_t csr_unpack(input logic [FCSR_W-1:0] w);
    csr_t c;
    c.fs    = w[FS_POS];
    c.cond  = w[COND_POS];
    c.cause = w[CAUSE_LO +: CAUSE_W];
    c.en    = w[EN_LO +: IEEE_N];
    c.flags = w[FLAG_LO +: IEEE_N];
    c.rm    = w[RM_LO +: RM_W];
    return c;
  endfunction

  function automatic logic [FCSR_W-1:0] csr_live_mask();
    csr_t ones;
    ones = '1;
    return csr_pack(ones);
  endfunction

endpackage

// File: rtl/fpcsr_trapcalc.sv
module fpcsr_trapcalc
  import fpcsr_pkg::*;
(
  input  logic                fs,
  input  logic [IEEE_N-1:0]   en,
  input  logic [IEEE_N-1:0]   op_exc,
  input  logic                op_unimpl,
  input  logic                op_denorm,
  output logic [CAUSE_W-1:0]  cause_new,
  output logic                trap
);

  logic                emul;
  logic [IEEE_N-1:0]   armed;

  // A denormal result needs emulation unless it is flushed to zero.
  assign emul = op_unimpl | (op_denorm & ~fs);

  genvar g;
  generate
    for (g = 0; g < IEEE_N; g++) begin : g_arm
      assign armed[g] = op_exc[g] & en[g];
    end
  endgenerate

  assign cause_new = {emul, op_exc};
  assign trap      = emul | (|armed);

endmodule

// File: rtl/fpcsr_regs.sv
module fpcsr_regs
  import fpcsr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [FCSR_W-1:0]   wr_data,
  input  logic                op_upd,
  input  logic                op_is_cmp,
  input  logic                cmp_true,
  input  logic [CAUSE_W-1:0]  cause_new,
  input  logic                trap,
  output csr_t                csr_q,
  output logic                exc_req
);

  csr_t               csr_d;
  logic [IEEE_N-1:0]  pend;

  always_comb begin
    csr_d = csr_q;
    if (wr_en) begin
      csr_d = csr_unpack(wr_data);
    end else if (op_upd) begin
      csr_d.cause = cause_new;
      if (!trap) begin
        csr_d.flags = csr_q.flags | cause_new[IEEE_N-1:0];
        if (op_is_cmp) csr_d.cond = cmp_true;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) csr_q <= '0;
    else        csr_q <= csr_d;
  end

  genvar g;
  generate
    for (g = 0; g < IEEE_N; g++) begin : g_pend
      assign pend[g] = csr_q.cause[g] & csr_q.en[g];
    end
  endgenerate

  assign exc_req = csr_q.cause[IEEE_N] | (|pend);

endmodule

// File: rtl/fpcsr_rdgate.sv
module fpcsr_rdgate
  import fpcsr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   busy,
  input  logic   trap_evt,
  output logic   req_ready,
  output logic   rsp_valid,
  output logic   rsp_abort,
  output rdst_e  st
);

  rdst_e st_d;
  logic  abort_q, abort_d;

  always_comb begin
    st_d    = st;
    abort_d = abort_q;
    case (st)
      RD_IDLE: begin
        abort_d = 1'b0;
        if (req_valid) st_d = RD_WAIT;
      end
      RD_WAIT: begin
        if (trap_evt) begin
          st_d    = RD_RESP;
          abort_d = 1'b1;
        end else if (!busy) begin
          st_d    = RD_RESP;
          abort_d = 1'b0;
        end
      end
      RD_RESP: st_d = RD_IDLE;
      default: st_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= RD_IDLE;
      abort_q <= 1'b0;
    end else begin
      st      <= st_d;
      abort_q <= abort_d;
    end
  end

  assign req_ready = (st == RD_IDLE);
  assign rsp_valid = (st == RD_RESP);
  assign rsp_abort = rsp_valid & abort_q;

endmodule

// File: rtl/fpcsr_ctrl.sv
module fpcsr_ctrl
  import fpcsr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic [1:0]          op_kind,
  input  logic [IEEE_N-1:0]   op_exc,
  input  logic                op_unimpl,
  input  logic                op_denorm,
  input  logic                op_cmp_true,
  output logic                op_commit,
  input  logic                fpu_busy,
  input  logic                sw_wr_en,
  input  logic [FCSR_W-1:0]   sw_wr_data,
  input  logic                rd_req_valid,
  output logic                rd_req_ready,
  output logic                rd_rsp_valid,
  output logic                rd_rsp_abort,
  output logic [FCSR_W-1:0]   rd_rsp_data,
  output logic [RM_W-1:0]     rnd_mode,
  output logic                flush_zero,
  output logic                cond_out,
  output logic                exc_req
);

  csr_t               csr_q;
  logic [CAUSE_W-1:0] cause_new;
  logic               trap;
  logic               is_arith, is_cmp, op_upd, trap_evt;
  rdst_e              rd_st;

  assign is_arith = (op_kind == OPK_ARITH);
  assign is_cmp   = (op_kind == OPK_CMP);
  // Software writes win over a report in the same cycle.
  assign op_upd   = op_valid & (is_arith | is_cmp) & ~sw_wr_en;
  assign trap_evt = op_upd & trap;
  assign op_commit = op_upd & ~trap;

  fpcsr_trapcalc u_trap (
    .fs        (csr_q.fs),
    .en        (csr_q.en),
    .op_exc    (op_exc),
    .op_unimpl (op_unimpl),
    .op_denorm (op_denorm),
    .cause_new (cause_new),
    .trap      (trap)
  );

  fpcsr_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (sw_wr_en),
    .wr_data   (sw_wr_data),
    .op_upd    (op_upd),
    .op_is_cmp (is_cmp),
    .cmp_true  (op_cmp_true),
    .cause_new (cause_new),
    .trap      (trap),
    .csr_q     (csr_q),
    .exc_req   (exc_req)
  );

  fpcsr_rdgate u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (rd_req_valid),
    .busy      (fpu_busy),
    .trap_evt  (trap_evt),
    .req_ready (rd_req_ready),
    .rsp_valid (rd_rsp_valid),
    .rsp_abort (rd_rsp_abort),
    .st        (rd_st)
  );

  assign rd_rsp_data = (rd_rsp_valid && !rd_rsp_abort) ? csr_pack(csr_q) : '0;
  assign rnd_mode    = csr_q.rm;
  assign flush_zero  = csr_q.fs;
  assign cond_out    = csr_q.cond;

endmodule

// File: rtl/fpcsr_ctrl_chk.sv
module fpcsr_ctrl_chk
  import fpcsr_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               sw_wr_en,
  input logic [FCSR_W-1:0]  sw_wr_data,
  input logic               op_valid,
  input logic [1:0]         op_kind,
  input logic               fpu_busy,
  input logic               rd_rsp_valid,
  input logic [FCSR_W-1:0]  rd_rsp_data,
  input logic               exc_req,
  input csr_t               csr_q,
  input logic               trap_evt,
  input rdst_e              rd_st
);

  localparam logic [FCSR_W-1:0] LIVE = csr_live_mask();

  AST_UNIMPL_ALWAYS_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    csr_q.cause[IEEE_N] |-> exc_req); // R6

  AST_FLAGS_NEVER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr_en |=> ((csr_q.flags & $past(csr_q.flags)) == $past(csr_q.flags))); // R8

  AST_TRAP_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    trap_evt |=> ($stable(csr_q.flags) && $stable(csr_q.cond))); // R7

  AST_MOVE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind[1] == op_kind[0] && !sw_wr_en) |=> $stable(csr_q)); // R5

  AST_WRITE_PAIR_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_en && |(sw_wr_data[CAUSE_LO +: IEEE_N] & sw_wr_data[EN_LO +: IEEE_N])) |=> exc_req); // R11

  AST_READ_HOLDS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_st == RD_WAIT && fpu_busy && !trap_evt) |=> !rd_rsp_valid); // R12

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_valid |-> ((rd_rsp_data & ~LIVE) == '0)); // R2

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en |=> (csr_pack(csr_q) == ($past(sw_wr_data) & LIVE))); // R14

endmodule

bind fpcsr_ctrl fpcsr_ctrl_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .sw_wr_en     (sw_wr_en),
  .sw_wr_data   (sw_wr_data),
  .op_valid     (op_valid),
  .op_kind      (op_kind),
  .fpu_busy     (fpu_busy),
  .rd_rsp_valid (rd_rsp_valid),
  .rd_rsp_data  (rd_rsp_data),
  .exc_req      (exc_req),
  .csr_q        (csr_q),
  .trap_evt     (trap_evt),
  .rd_st        (rd_st)
);

// File: tb/fpcsr_ctrl_tb_top.sv
module fpcsr_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, op_unimpl, op_denorm, op_cmp_true, op_commit;
  logic [1:0]  op_kind;
  logic [4:0]  op_exc;
  logic        fpu_busy, sw_wr_en;
  logic [31:0] sw_wr_data;
  logic        rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_abort;
  logic [31:0] rd_rsp_data;
  logic [1:0]  rnd_mode;
  logic        flush_zero, cond_out, exc_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  fpcsr_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_kind(op_kind), .op_exc(op_exc),
    .op_unimpl(op_unimpl), .op_denorm(op_denorm), .op_cmp_true(op_cmp_true),
    .op_commit(op_commit), .fpu_busy(fpu_busy),
    .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_abort(rd_rsp_abort),
    .rd_rsp_data(rd_rsp_data), .rnd_mode(rnd_mode), .flush_zero(flush_zero),
    .cond_out(cond_out), .exc_req(exc_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // All tasks start and end just after a rising edge.
  task automatic wr(input logic [31:0] d);
    sw_wr_en = 1'b1; sw_wr_data = d;
    @(posedge clk); #1;
    sw_wr_en = 1'b0;
  endtask

  task automatic op(input logic [1:0] k, input logic [4:0] x, input logic u,
                    input logic dn, input logic ct, output logic commit);
    op_valid = 1'b1; op_kind = k; op_exc = x; op_unimpl = u;
    op_denorm = dn; op_cmp_true = ct;
    @(negedge clk); commit = op_commit;
    @(posedge clk); #1;
    op_valid = 1'b0; op_exc = '0; op_unimpl = 1'b0; op_denorm = 1'b0;
  endtask

  task automatic rd_issue();
    rd_req_valid = 1'b1;
    @(negedge clk);
    chk("R12 ready when idle", {31'b0, rd_req_ready}, 32'd1);
    @(posedge clk); #1;
    rd_req_valid = 1'b0;
  endtask

  task automatic rd_collect(output logic [31:0] d, output logic ab);
    d = '0; ab = 1'b0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (rd_rsp_valid) begin
        d = rd_rsp_data; ab = rd_rsp_abort;
        @(posedge clk); #1;
        return;
      end
      @(posedge clk); #1;
    end
    chk("R12 response missing", 32'd0, 32'd1);
  endtask

  task automatic rd(output logic [31:0] d, output logic ab);
    rd_issue();
    rd_collect(d, ab);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    if (!done) $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic ab, cm, exp_trap;
    rst_n = 1'b0; op_valid = 0; op_kind = 0; op_exc = 0; op_unimpl = 0;
    op_denorm = 0; op_cmp_true = 0; fpu_busy = 0; sw_wr_en = 0; sw_wr_data = 0;
    rd_req_valid = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 outputs", {27'b0, rnd_mode, flush_zero, cond_out, exc_req}, 32'd0);
    @(posedge clk); #1;
    rd(d, ab);
    chk("R1 word", d, 32'd0);

    // R2 / R3 all-ones write
    wr(32'hFFFF_FFFF);
    @(negedge clk);
    chk("R3 outputs after ones", {28'b0, rnd_mode, flush_zero, cond_out}, 32'hF);
    chk("R6 exc after ones", {31'b0, exc_req}, 32'd1);
    @(posedge clk); #1;
    rd(d, ab);
    chk("R2 live bits", d, 32'h0183_FFFF);

    // R3 rounding mode and flush control
    for (int r = 0; r < 4; r++) begin
      wr(32'(r) | (32'(r & 1) << 24));
      @(negedge clk);
      chk("R3 rnd_mode", {30'b0, rnd_mode}, 32'(r));
      chk("R3 flush_zero", {31'b0, flush_zero}, 32'(r & 1));
      @(posedge clk); #1;
    end

    // R5 move kinds leave state alone
    wr(32'h0080_1020);
    op(2'b00, 5'h1F, 1'b1, 1'b1, 1'b0, cm);
    chk("R5 commit move", {31'b0, cm}, 32'd0);
    op(2'b11, 5'h1F, 1'b1, 1'b0, 1'b0, cm);
    chk("R5 commit xmove", {31'b0, cm}, 32'd0);
    rd(d, ab);
    chk("R5 word after moves", d, 32'h0080_1020);

    // R9 compares
    wr(32'h0);
    op(2'b10, 5'h0, 1'b0, 1'b0, 1'b1, cm);
    chk("R9 commit", {31'b0, cm}, 32'd1);
    @(negedge clk); chk("R9 cond true", {31'b0, cond_out}, 32'd1); @(posedge clk); #1;
    op(2'b10, 5'h0, 1'b0, 1'b0, 1'b0, cm);
    @(negedge clk); chk("R9 cond false", {31'b0, cond_out}, 32'd0); @(posedge clk); #1;

    // R7 trapping compare: cause only
    wr(32'h0000_0800);
    op(2'b10, 5'h10, 1'b0, 1'b0, 1'b1, cm);
    chk("R7 commit low", {31'b0, cm}, 32'd0);
    rd(d, ab);
    chk("R7 trapping compare word", d, 32'h0001_0800);

    // R4 / R8 sticky flags
    wr(32'h0);
    op(2'b01, 5'h01, 1'b0, 1'b0, 1'b0, cm);
    chk("R8 commit", {31'b0, cm}, 32'd1);
    op(2'b01, 5'h08, 1'b0, 1'b0, 1'b0, cm);
    rd(d, ab);
    chk("R4 R8 word", d, 32'h0000_8024);
    op(2'b01, 5'h00, 1'b0, 1'b0, 1'b0, cm);
    rd(d, ab);
    chk("R8 flags kept", d, 32'h0000_0024);

    // R10 denormal handling
    wr(32'h0);
    op(2'b01, 5'h0, 1'b0, 1'b1, 1'b0, cm);
    chk("R10 commit no flush", {31'b0, cm}, 32'd0);
    @(negedge clk); chk("R10 exc no flush", {31'b0, exc_req}, 32'd1); @(posedge clk); #1;
    rd(d, ab);
    chk("R10 word no flush", d, 32'h0002_0000);
    wr(32'h0100_0000);
    op(2'b01, 5'h0, 1'b0, 1'b1, 1'b0, cm);
    chk("R10 commit flush", {31'b0, cm}, 32'd1);
    rd(d, ab);
    chk("R10 word flush", d, 32'h0100_0000);

    // R11 write-induced trap
    wr(32'h0001_0800);
    @(negedge clk); chk("R11 V pair", {31'b0, exc_req}, 32'd1); @(posedge clk); #1;
    wr(32'h0001_0000);
    @(negedge clk); chk("R11 no enable", {31'b0, exc_req}, 32'd0); @(posedge clk); #1;
    wr(32'h0000_1080);
    @(negedge clk); chk("R11 I pair", {31'b0, exc_req}, 32'd1); @(posedge clk); #1;

    // R12 read stalls while busy
    wr(32'h0000_0003);
    fpu_busy = 1'b1;
    rd_issue();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R12 no early response", {31'b0, rd_rsp_valid}, 32'd0);
      @(posedge clk); #1;
    end
    fpu_busy = 1'b0;
    rd_collect(d, ab);
    chk("R12 data after drain", d, 32'h0000_0003);
    chk("R12 no abort", {31'b0, ab}, 32'd0);

    // R13 trap while waiting
    wr(32'h0000_0800);
    fpu_busy = 1'b1;
    rd_issue();
    op(2'b01, 5'h10, 1'b0, 1'b0, 1'b0, cm);
    rd_collect(d, ab);
    chk("R13 abort", {31'b0, ab}, 32'd1);
    chk("R13 data zero", d, 32'h0);
    fpu_busy = 1'b0;

    // R14 write beats operation
    sw_wr_en = 1'b1; sw_wr_data = 32'h0000_0002;
    op(2'b01, 5'h10, 1'b1, 1'b0, 1'b0, cm);
    sw_wr_en = 1'b0;
    chk("R14 commit dropped", {31'b0, cm}, 32'd0);
    rd(d, ab);
    chk("R14 written word", d, 32'h0000_0002);

    // Sweep: every enable mask against every cause report (R4 R6 R7 R8)
    for (int en = 0; en < 32; en++) begin
      for (int x = 0; x < 64; x++) begin
        wr((32'(en) << 7) | 32'(en & 3));
        exp_trap = x[5] | (|(x[4:0] & en[4:0]));
        op(2'b01, x[4:0], x[5], 1'b0, 1'b0, cm);
        chk("R7 R8 sweep commit", {31'b0, cm}, {31'b0, ~exp_trap});
        @(negedge clk);
        chk("R6 sweep exc_req", {31'b0, exc_req}, {31'b0, exp_trap});
        @(posedge clk); #1;
        rd(d, ab);
        chk("R4 sweep word", d, (32'(x) << 12) | (32'(en) << 7) |
            (exp_trap ? 32'h0 : (32'(x & 31) << 2)) | 32'(en & 3));
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule